// File: doc/BRIEF.md
# Display Configuration Register with Blink Timebase

This block keeps the eight-bit configuration byte of a segment display controller and produces the blink timing shared by the cursor and annunciator segments. A decoded command bus supplies write and read strobes, an address and a data byte. A write to the configuration address updates the stored mode bits. Two command bits act as one-shot triggers instead of stored bits: one clears all segment and annunciator memory, and the other restarts the blink timebase and the multiplex scan. A read of the configuration address returns the stored bits, and the top bit of the returned byte carries the live blink phase.

Writes to any other address are passed on as a registered write enable. While the lock bit is set, that enable is withheld for three protected configuration addresses. The font and display-mode bits are brought out for the font mapper and the multiplexer. The blink half-period is a cycle count chosen by the rate bit. Both counts are parameters: 4,000,000 and 2,000,000 cycles at a 4 MHz scan clock.

Top module: `dcfg_ctrl`

## Requirements
- R1: Synchronous reset clears every stored configuration bit, leaves `blink_on` high with the blink counter at zero, and holds `clear_all`, `mux_restart`, `fwd_we` and `rd_valid` low.
- R2: A read with `cmd_addr` equal to the configuration address (default 0x04) raises `rd_valid` for one cycle on the next clock. `rd_data` then holds bit 7 = phase, bit 6 = mode, bit 5 = 0, bit 4 = 0, bit 3 = font, bit 2 = rate, bit 1 = lock and bit 0 = the spare bit S, as last written to bits 6, 3, 2, 1 and 0.
- R3: Bit 7 of the read value equals the blink phase held in the cycle the read strobe was sampled, whether that phase is on or off.
- R4: `font16` follows written bit 3 and `mode_one_digit` follows written bit 6, both from the clock after the write.
- R5: A configuration write with bit 5 set drives `clear_all` high for exactly one cycle after the write, and bit 5 always reads back as 0.
- R6: A configuration write with bit 4 set drives `mux_restart` high for one cycle after the write, and bit 4 reads back as 0. The blink counter restarts at that write, and `blink_on` is then high for one full half-period before it falls.
- R7: With bit 2 clear, `blink_on` stays in each state for SLOW_HALF cycles.
- R8: With bit 2 set, `blink_on` stays in each state for FAST_HALF cycles.
- R9: `fwd_we` rises one cycle after a write to any address other than the configuration address. It stays low for a write to the configuration address, and for writes to 0x03, 0x06 or 0x0E while the lock bit (bit 1) is set. The map pointer address 0x05 and other addresses still pass while locked.
- R10: The configuration address stays writable while locked. Writing bit 1 as 0 removes the protection from the next command onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_wr | input | 1 | Write strobe of the decoded command |
| cmd_rd | input | 1 | Read strobe of the decoded command |
| cmd_addr | input | 8 | Command address |
| cmd_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data of a configuration read is valid |
| rd_data | output | 8 | Configuration byte with live phase in bit 7 |
| fwd_we | output | 1 | Write enable passed to the other configuration registers |
| blink_on | output | 1 | Blink phase, high = blinking segments lit |
| mux_restart | output | 1 | One-cycle restart pulse for the multiplex scan |
| clear_all | output | 1 | One-cycle clear pulse for digit and annunciator memory |
| font16 | output | 1 | 16-segment font selected |
| mode_one_digit | output | 1 | One digit per grid with annunciators |

## Verification
Every command result is due exactly one clock after the strobe: `rd_valid`/`rd_data`, `fwd_we`, both pulses, and the font and mode outputs. The driver records the expected values for each cycle it drives, and a monitor compares them just after the next rising edge. Blink timing is counted from the restarting write: `blink_on` is sampled on each falling edge after it and must be high for the first half-period, low for the second and high again after that. The phase bit in a read is compared with the `blink_on` level seen in the cycle the read was issued.

// File: rtl/dcfg_pkg.sv
package dcfg_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  localparam int BIT_S = 0;
  localparam int BIT_L = 1;
  localparam int BIT_B = 2;
  localparam int BIT_F = 3;
  localparam int BIT_T = 4;
  localparam int BIT_R = 5;
  localparam int BIT_M = 6;
  localparam int BIT_P = 7;

  typedef struct packed {
    logic mode;
    logic font;
    logic rate;
    logic lock;
    logic spare;
  } cfg_t;
endpackage

// File: rtl/dcfg_blink.sv
module dcfg_blink #(
  parameter int SLOW_HALF = 4000000,
  parameter int FAST_HALF = 2000000
) (
  input  logic clk,
  input  logic rst,
  input  logic fast_i,
  input  logic restart_i,
  output logic phase_o
);
  localparam int CW = (SLOW_HALF > 2) ? $clog2(SLOW_HALF) : 1;
  localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_HALF - 1);
  localparam logic [CW-1:0] FAST_LIM = CW'(FAST_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          ph_q;
  logic [CW-1:0] lim;

  assign lim = fast_i ? FAST_LIM : SLOW_LIM;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt_q <= '0;
      ph_q  <= 1'b1;
    end else if (cnt_q >= lim) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o = ph_q;

  // R7: the counter never passes the longest half-period
  a_r7_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= SLOW_LIM);

  // R6: a restart leaves the phase on and the counter at zero
  a_r6_restart_phase: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (ph_q && cnt_q == '0));

  // R1: reset leaves the phase on
  a_r1_reset_phase: assert property (@(posedge clk)
    rst |=> (ph_q && cnt_q == '0));
endmodule

// File: rtl/dcfg_regs.sv
module dcfg_regs
  import dcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              phase_i,
  output logic              font_o,
  output logic              mode_o,
  output logic              fast_o,
  output logic              lock_o,
  output logic              clr_o,
  output logic              resync_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  cfg_t              cfg_q;
  logic              clr_q, resync_q, rdv_q;
  logic [DATA_W-1:0] rdd_q;
  logic              wsel, rsel;
  logic [DATA_W-1:0] rd_word;

  assign wsel = wr_i & sel_i;
  assign rsel = rd_i & sel_i;

  always_comb begin
    rd_word        = '0;
    rd_word[BIT_P] = phase_i;
    rd_word[BIT_M] = cfg_q.mode;
    rd_word[BIT_F] = cfg_q.font;
    rd_word[BIT_B] = cfg_q.rate;
    rd_word[BIT_L] = cfg_q.lock;
    rd_word[BIT_S] = cfg_q.spare;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      clr_q    <= 1'b0;
      resync_q <= 1'b0;
      rdv_q    <= 1'b0;
      rdd_q    <= '0;
    end else begin
      clr_q    <= wsel & wdata_i[BIT_R];
      resync_q <= wsel & wdata_i[BIT_T];
      rdv_q    <= rsel;
      if (rsel) rdd_q <= rd_word;
      if (wsel) begin
        cfg_q.mode  <= wdata_i[BIT_M];
        cfg_q.font  <= wdata_i[BIT_F];
        cfg_q.rate  <= wdata_i[BIT_B];
        cfg_q.lock  <= wdata_i[BIT_L];
        cfg_q.spare <= wdata_i[BIT_S];
      end
    end
  end

  assign font_o     = cfg_q.font;
  assign mode_o     = cfg_q.mode;
  assign fast_o     = cfg_q.rate;
  assign lock_o     = cfg_q.lock;
  assign clr_o      = clr_q;
  assign resync_o   = resync_q;
  assign rd_valid_o = rdv_q;
  assign rd_data_o  = rdd_q;

  // R1: reset clears the stored bits and the pulses
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (cfg_q == '0 && !clr_q && !resync_q && !rdv_q));

  // R5: a clear pulse only follows a config write with the clear bit
  a_r5_clr_cause: assert property (@(posedge clk) disable iff (rst)
    clr_q |-> $past(wr_i && sel_i && wdata_i[BIT_R]));

  // R2: trigger bits always read back as zero
  a_r2_trig_zero: assert property (@(posedge clk) disable iff (rst)
    rdv_q |-> (rdd_q[BIT_R] == 1'b0 && rdd_q[BIT_T] == 1'b0));

  // R3: phase bit matches the phase at the read
  a_r3_phase_read: assert property (@(posedge clk) disable iff (rst)
    rsel |=> (rdd_q[BIT_P] == $past(phase_i)));
endmodule

// File: rtl/dcfg_guard.sv
module dcfg_guard #(
  parameter int                     AW        = 8,
  parameter int                     N_PROT    = 3,
  parameter logic [N_PROT*AW-1:0]   PROT_LIST = {8'h0E, 8'h06, 8'h03}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic          sel_i,
  input  logic [AW-1:0] addr_i,
  input  logic          lock_i,
  output logic          we_o
);
  logic [N_PROT-1:0] hit;
  logic              blocked;
  logic              we_q;

  for (genvar i = 0; i < N_PROT; i++) begin : g_match
    assign hit[i] = (addr_i == PROT_LIST[i*AW +: AW]);
  end

  assign blocked = lock_i & (|hit);

  always_ff @(posedge clk) begin
    if (rst) we_q <= 1'b0;
    else     we_q <= wr_i & ~sel_i & ~blocked;
  end

  assign we_o = we_q;

  // R9: a locked protected write never reaches the enable
  a_r9_lock_blocks: assert property (@(posedge clk) disable iff (rst)
    (wr_i && lock_i && (|hit)) |=> !we_q);

  // R9: the enable only follows a write
  a_r9_we_cause: assert property (@(posedge clk) disable iff (rst)
    we_q |-> $past(wr_i && !sel_i));
endmodule

// File: rtl/dcfg_ctrl.sv
module dcfg_ctrl
  import dcfg_pkg::*;
#(
  parameter logic [ADDR_W-1:0]       CFG_ADDR  = 8'h04,
  parameter int                      N_PROT    = 3,
  parameter logic [N_PROT*ADDR_W-1:0] PROT_LIST = {8'h0E, 8'h06, 8'h03},
  parameter int                      SLOW_HALF = 4000000,
  parameter int                      FAST_HALF = 2000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic              cmd_rd,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              fwd_we,
  output logic              blink_on,
  output logic              mux_restart,
  output logic              clear_all,
  output logic              font16,
  output logic              mode_one_digit
);
  logic sel, restart, fast, lock, phase;

  assign sel     = (cmd_addr == CFG_ADDR);
  assign restart = cmd_wr & sel & cmd_wdata[BIT_T];

  dcfg_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_i       (cmd_wr),
    .rd_i       (cmd_rd),
    .sel_i      (sel),
    .wdata_i    (cmd_wdata),
    .phase_i    (phase),
    .font_o     (font16),
    .mode_o     (mode_one_digit),
    .fast_o     (fast),
    .lock_o     (lock),
    .clr_o      (clear_all),
    .resync_o   (mux_restart),
    .rd_valid_o (rd_valid),
    .rd_data_o  (rd_data)
  );

  dcfg_blink #(
    .SLOW_HALF (SLOW_HALF),
    .FAST_HALF (FAST_HALF)
  ) u_blink (
    .clk       (clk),
    .rst       (rst),
    .fast_i    (fast),
    .restart_i (restart),
    .phase_o   (phase)
  );

  dcfg_guard #(
    .AW        (ADDR_W),
    .N_PROT    (N_PROT),
    .PROT_LIST (PROT_LIST)
  ) u_guard (
    .clk    (clk),
    .rst    (rst),
    .wr_i   (cmd_wr),
    .sel_i  (sel),
    .addr_i (cmd_addr),
    .lock_i (lock),
    .we_o   (fwd_we)
  );

  assign blink_on = phase;

  // R6: the scan restart pulse comes with a fresh blink-on phase
  a_r6_pulse_phase: assert property (@(posedge clk) disable iff (rst)
    mux_restart |-> blink_on);
endmodule

// File: tb/tb_dcfg_ctrl.sv
module tb_dcfg_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SLOW = 12;
  localparam int FAST = 6;
  localparam logic [7:0] CFG = 8'h04;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_wr = 1'b0, cmd_rd = 1'b0;
  logic [7:0] cmd_addr = '0, cmd_wdata = '0;
  logic       rd_valid, fwd_we, blink_on, mux_restart, clear_all, font16, mode_one_digit;
  logic [7:0] rd_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct packed {
    logic       rdv;
    logic [7:0] rd;
    logic       we;
    logic       clr;
    logic       mux;
    logic       f16;
    logic       m1;
  } exp_t;

  exp_t  q[$];
  string tq[$];
  logic [7:0] m_cfg = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcfg_ctrl #(.SLOW_HALF(SLOW), .FAST_HALF(FAST)) dut (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .fwd_we(fwd_we), .blink_on(blink_on),
    .mux_restart(mux_restart), .clear_all(clear_all), .font16(font16),
    .mode_one_digit(mode_one_digit)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic prot(input logic [7:0] a);
    return (a == 8'h03) || (a == 8'h06) || (a == 8'h0E);
  endfunction

  // driver: one command per falling edge, expected outputs pushed
  task automatic cmd(input logic wr, input logic rd, input logic [7:0] a,
                     input logic [7:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    cmd_wr = wr; cmd_rd = rd; cmd_addr = a; cmd_wdata = d;
    e.rdv = rd && (a == CFG);
    e.rd  = {blink_on, m_cfg[6], 2'b00, m_cfg[3:0]};
    e.we  = wr && (a != CFG) && !(m_cfg[1] && prot(a));
    e.clr = wr && (a == CFG) && d[5];
    e.mux = wr && (a == CFG) && d[4];
    if (wr && a == CFG) m_cfg = d & 8'h4F;
    e.f16 = m_cfg[3];
    e.m1  = m_cfg[6];
    q.push_back(e);
    tq.push_back(tag);
  endtask

  task automatic idle(input string tag);
    cmd(1'b0, 1'b0, 8'h00, 8'h00, tag);
  endtask

  // monitor: results are due one clock after the command
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t  e;
        string t;
        e = q.pop_front();
        t = tq.pop_front();
        check(t, {3'b0, rd_valid, (e.rdv ? rd_data : 8'h00), fwd_we, clear_all, mux_restart, font16, mode_one_digit},
                 {3'b0, e.rdv, (e.rdv ? e.rd : 8'h00), e.we, e.clr, e.mux, e.f16, e.m1});
      end
    end
  end

  // blink span: restarting write issued just before this call
  task automatic blink_span(input int half, input string tag);
    for (int j = 0; j <= 2*half; j++) begin
      idle(tag);
      check(tag, {15'b0, blink_on}, {15'b0, (j < half || j == 2*half) ? 1'b1 : 1'b0});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 reset", {10'b0, rd_valid, fwd_we, blink_on, mux_restart, clear_all, font16},
                      {10'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0});
    cmd(1'b0, 1'b1, CFG, 8'h00, "R1 R2 R3 reset readback");
    // R2 R4 store and read back
    cmd(1'b1, 1'b0, CFG, 8'h4D, "R4 write mode font rate spare");
    cmd(1'b0, 1'b1, CFG, 8'h00, "R2 readback layout");
    cmd(1'b1, 1'b0, CFG, 8'h0A, "R4 mode cleared");
    cmd(1'b0, 1'b1, CFG, 8'h00, "R2 readback second pattern");
    // R5 R6 pulses, R7 slow span
    cmd(1'b1, 1'b0, CFG, 8'h38, "R5 R6 clear and restart");
    blink_span(SLOW, "R6 R7 slow blink");
    cmd(1'b0, 1'b1, CFG, 8'h00, "R5 R6 trigger bits read zero");
    // R8 fast span
    cmd(1'b1, 1'b0, CFG, 8'h14, "R6 R8 fast restart");
    blink_span(FAST, "R8 fast blink");
    // R3 phase off readback
    cmd(1'b1, 1'b0, CFG, 8'h10, "R6 slow restart");
    for (int k = 0; k < SLOW + 2; k++) idle("R3 wait");
    check("R3 phase low before read", {15'b0, blink_on}, 16'h0000);
    cmd(1'b0, 1'b1, CFG, 8'h00, "R3 phase off in read");
    // R9 forwarding unlocked
    cmd(1'b1, 1'b0, 8'h03, 8'h11, "R9 unlocked grids");
    cmd(1'b1, 1'b0, 8'h0E, 8'h11, "R9 unlocked shift limit");
    cmd(1'b1, 1'b0, CFG, 8'h02, "R9 config write not forwarded, lock set");
    cmd(1'b1, 1'b0, 8'h03, 8'h22, "R9 locked grids");
    cmd(1'b1, 1'b0, 8'h06, 8'h22, "R9 locked map data");
    cmd(1'b1, 1'b0, 8'h0E, 8'h22, "R9 locked shift limit");
    cmd(1'b1, 1'b0, 8'h05, 8'h22, "R9 locked map pointer passes");
    cmd(1'b1, 1'b0, 8'h01, 8'h22, "R9 locked other passes");
    cmd(1'b0, 1'b1, CFG, 8'h00, "R10 lock reads back");
    // R10 release lock
    cmd(1'b1, 1'b0, CFG, 8'h00, "R10 lock release");
    cmd(1'b1, 1'b0, 8'h06, 8'h33, "R10 map data open again");
    cmd(1'b1, 1'b0, 8'h0E, 8'h33, "R10 shift limit open again");
    idle("R5 R6 R9 idle");
    idle("R5 R6 R9 idle");
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule